// File: doc/BRIEF.md
# Debug Firmware Command Executor

This block runs on the target side of a debug link. It accepts an 8-bit command code, together with a 16-bit word when the command writes. It carries out that command on a five-entry CPU register set: program counter, D accumulator, X index, Y index and stack pointer. Two commands step the X register forward by two and then read or write memory at the new X, using a request/acknowledge port. Every value produced for the host lands in a 16-bit output shifter. The serial side of the link clocks that shifter out one bit at a time, most significant bit first.

Three further commands do not touch the register set. Each raises a single-cycle control pulse toward the CPU core:
- resume the user program;
- execute one instruction and come back;
- enable instruction tagging and resume.

A one-cycle completion pulse tells the link side that a command has finished. The link side decodes the serial bits into a command code and offers it with a valid strobe. Codes the block does not know, and codes offered while a memory access is still outstanding, are dropped.

Top module: `dbg_cmd_exec`

## Requirements
- R1: After synchronous active-low reset, all five registers and the shifter hold 0. `done`, `busy`, `mem_req`, `go_pulse`, `step_pulse` and `tag_go_pulse` are low.
- R2: Codes 0x63, 0x64, 0x65, 0x66 and 0x67 copy PC, D, X, Y and SP respectively into the shifter. `done` is high in the cycle after the code is accepted.
- R3: Codes 0x43, 0x44, 0x45, 0x46 and 0x47 write `cmd_wdata` into PC, D, X, Y and SP respectively. `done` is high in the cycle after acceptance.
- R4: Code 0x62 adds 2 to X and then issues a memory read at the new X (`mem_we`=0). The shifter takes `mem_rdata` on the acknowledge edge. `done` is high in the cycle after the acknowledge.
- R5: Code 0x42 adds 2 to X and then issues a memory write of `cmd_wdata` at the new X (`mem_we`=1). `done` is high in the cycle after the acknowledge. The shifter is not changed.
- R6: `mem_req` rises in the cycle after a memory command is accepted. It holds, with `mem_addr`, `mem_we` and `mem_wdata` stable, until a cycle with `mem_ack` high, and it is low in the cycle after that.
- R7: Code 0x08 gives a one-cycle `go_pulse`, high together with `done` in the cycle after acceptance.
- R8: Code 0x10 gives a one-cycle `step_pulse`, high together with `done` in the cycle after acceptance.
- R9: Code 0x18 gives a one-cycle `tag_go_pulse`, high together with `done` in the cycle after acceptance.
- R10: Any other code raises neither `done` nor any pulse, and leaves all registers and the shifter unchanged.
- R11: `busy` is high from the cycle after a memory command is accepted until the acknowledge edge. A command offered while `busy` is high is ignored.
- R12: When no load occurs, `shift_en` shifts the shifter left by one and brings in a 0. `ser_out` always equals shifter bit 15. A load in the same cycle takes priority over the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command code offered this cycle |
| cmd_op | input | 8 | Command code |
| cmd_wdata | input | 16 | Data word for write commands |
| shift_en | input | 1 | Shift the output shifter left by one |
| busy | output | 1 | Memory access outstanding; commands ignored |
| done | output | 1 | One-cycle completion pulse |
| shift_q | output | 16 | Output shifter contents |
| ser_out | output | 1 | Shifter bit 15 |
| go_pulse | output | 1 | Resume user program |
| step_pulse | output | 1 | Execute one instruction, then return |
| tag_go_pulse | output | 1 | Enable tagging and resume |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
Register, control and unknown-code commands settle one cycle after the accepting edge. The bench drives the code at a falling edge, drops the valid strobe at the next falling edge, and reads `done`, the pulses and the shifter right there, half a period after the edge that accepted the command.

Memory commands first show `mem_req`, `busy` and the new X address at that same point. The bench then holds off the acknowledge for a random zero to three cycles, re-checking that the request is steady each cycle. It raises `mem_ack` for exactly one edge and looks for `done` and the read data one falling edge later.

Shifter contents after a run of shifts are compared against the expected word moved left by the shift count.

// File: rtl/dbg_cmd_pkg.sv
// Shared constants and types for the debug firmware command executor.
// Assumes 8-bit command codes and a five-entry register set in the order
// PC, D, X, Y, SP, which the code-to-index mapping depends on.
package dbg_cmd_pkg;

    localparam logic [7:0] OP_RD_NEXT = 8'h62;
    localparam logic [7:0] OP_RD_BASE = 8'h63;
    localparam logic [7:0] OP_WR_NEXT = 8'h42;
    localparam logic [7:0] OP_WR_BASE = 8'h43;
    localparam logic [7:0] OP_GO      = 8'h08;
    localparam logic [7:0] OP_STEP    = 8'h10;
    localparam logic [7:0] OP_TAGGO   = 8'h18;

    typedef enum logic [2:0] {
        K_NONE,
        K_RDREG,
        K_WRREG,
        K_RDMEM,
        K_WRMEM,
        K_GO,
        K_STEP,
        K_TAGGO
    } cmd_kind_e;

    typedef enum logic {
        S_IDLE,
        S_MEM
    } exec_state_e;

endpackage

// File: rtl/dbg_cmd_decode.sv
// Combinational command-code decoder.
// Maps an 8-bit code to a command kind and, for register commands, to a
// register index. Assumes the register block is contiguous and NREG long.
module dbg_cmd_decode
    import dbg_cmd_pkg::*;
#(
    parameter int unsigned NREG = 5,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic [7:0]    op,
    output cmd_kind_e     kind,
    output logic [IW-1:0] reg_idx
);

    logic [7:0] rd_off;
    logic [7:0] wr_off;

    assign rd_off = op - OP_RD_BASE;
    assign wr_off = op - OP_WR_BASE;

    // Classify the code and derive the register index from its offset.
    always_comb begin
        kind    = K_NONE;
        reg_idx = '0;
        if (rd_off < 8'(NREG)) begin
            kind    = K_RDREG;
            reg_idx = rd_off[IW-1:0];
        end else if (wr_off < 8'(NREG)) begin
            kind    = K_WRREG;
            reg_idx = wr_off[IW-1:0];
        end else begin
            case (op)
                OP_RD_NEXT: kind = K_RDMEM;
                OP_WR_NEXT: kind = K_WRMEM;
                OP_GO:      kind = K_GO;
                OP_STEP:    kind = K_STEP;
                OP_TAGGO:   kind = K_TAGGO;
                default:    kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dbg_regfile.sv
// CPU register set seen by the debug executor.
// One write port plus an auto-increment of the index register at X_IDX.
// Assumes the caller never asserts a write and an increment in the same cycle.
module dbg_regfile #(
    parameter int unsigned DW    = 16,
    parameter int unsigned NREG  = 5,
    parameter int unsigned X_IDX = 2,
    parameter int unsigned STEP  = 2,
    localparam int unsigned IW   = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     inc_x,
    output logic [NREG-1:0][DW-1:0]  regs
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r;

        // Hold one register: reset, write, or (X only) step forward.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                r <= wr_data;
            end else if (inc_x && g == X_IDX) begin
                r <= r + DW'(STEP);
            end
        end

        assign regs[g] = r;
    end

    // R4/R5: write and X increment come from exclusive command kinds.
    a_r4_inc_write_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_x && wr_en));

endmodule

// File: rtl/dbg_mem_port.sv
// Request/acknowledge memory port for word accesses.
// A start loads address, data and direction and raises the request, which
// holds until acknowledged. Assumes start only arrives while idle.
module dbg_mem_port #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          fin
);

    // Launch a request on start and retire it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (start) begin
            mem_req   <= 1'b1;
            mem_we    <= start_we;
            mem_addr  <= start_addr;
            mem_wdata <= start_wdata;
        end else if (mem_req && mem_ack) begin
            mem_req   <= 1'b0;
        end
    end

    assign fin = mem_req && mem_ack;

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    a_r6_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);
    a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !start);

endmodule

// File: rtl/dbg_shifter.sv
// Output shifter toward the serial link: parallel load, left shift with
// zero fill, MSB presented as the serial bit. Load wins over shift.
module dbg_shifter #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          shift_en,
    output logic [DW-1:0] q,
    output logic          ser_out
);

    // Load a result or move one bit toward the serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_data;
        end else if (shift_en) begin
            q <= {q[DW-2:0], 1'b0};
        end
    end

    assign ser_out = q[DW-1];

    a_r12_shift_fill: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && !load |=> q[0] == 1'b0);

endmodule

// File: rtl/dbg_cmd_exec.sv
// Debug firmware command executor (top).
// Accepts a code when idle. Register, control and unknown codes finish in
// one cycle; memory codes step X by two and wait for the memory acknowledge.
// Assumes the register set is ordered PC, D, X, Y, SP.
module dbg_cmd_exec
    import dbg_cmd_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned NREG  = 5,
    parameter int unsigned X_IDX = 2,
    localparam int unsigned IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_op,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          shift_en,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] shift_q,
    output logic          ser_out,
    output logic          go_pulse,
    output logic          step_pulse,
    output logic          tag_go_pulse,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);

    exec_state_e             state_q;
    cmd_kind_e               kind;
    logic [IW-1:0]           idx;
    logic [NREG-1:0][DW-1:0] regs;
    logic                    accept;
    logic                    is_mem;
    logic                    one_cycle;
    logic                    fin;
    logic                    sh_load;
    logic [DW-1:0]           sh_data;
    logic [DW-1:0]           next_x;

    dbg_cmd_decode #(.NREG(NREG)) u_dec (
        .op      (cmd_op),
        .kind    (kind),
        .reg_idx (idx)
    );

    assign accept    = cmd_valid && (state_q == S_IDLE);
    assign is_mem    = (kind == K_RDMEM) || (kind == K_WRMEM);
    assign one_cycle = (kind != K_NONE) && !is_mem;
    assign next_x    = regs[X_IDX] + DW'(2);

    dbg_regfile #(.DW(DW), .NREG(NREG), .X_IDX(X_IDX), .STEP(2)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && kind == K_WRREG),
        .wr_idx  (idx),
        .wr_data (cmd_wdata),
        .inc_x   (accept && is_mem),
        .regs    (regs)
    );

    dbg_mem_port #(.DW(DW), .AW(DW)) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept && is_mem),
        .start_we    (kind == K_WRMEM),
        .start_addr  (next_x),
        .start_wdata (cmd_wdata),
        .mem_ack     (mem_ack),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .fin         (fin)
    );

    assign sh_load = (accept && kind == K_RDREG) || (fin && !mem_we);
    assign sh_data = (state_q == S_MEM) ? mem_rdata : regs[idx];

    dbg_shifter #(.DW(DW)) u_sh (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_data (sh_data),
        .shift_en  (shift_en),
        .q         (shift_q),
        .ser_out   (ser_out)
    );

    // Track whether a memory access is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else if (accept && is_mem) begin
            state_q <= S_MEM;
        end else if (fin) begin
            state_q <= S_IDLE;
        end
    end

    // Register the completion pulse and the CPU control pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            go_pulse     <= 1'b0;
            step_pulse   <= 1'b0;
            tag_go_pulse <= 1'b0;
        end else begin
            done         <= (accept && one_cycle) || fin;
            go_pulse     <= accept && kind == K_GO;
            step_pulse   <= accept && kind == K_STEP;
            tag_go_pulse <= accept && kind == K_TAGGO;
        end
    end

    assign busy = (state_q == S_MEM);

    a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_pulse, step_pulse, tag_go_pulse}));
    a_r9_pulse_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pulse || step_pulse || tag_go_pulse) |-> done);
    a_r11_req_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    a_r4_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mem_ack |=> done && !busy);
    a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done);

endmodule

// File: tb/dbg_cmd_exec_test.sv
module dbg_cmd_exec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [15:0] cmd_wdata = '0;
    logic        shift_en = 1'b0;
    logic        busy, done, ser_out, go_pulse, step_pulse, tag_go_pulse;
    logic        mem_req, mem_we;
    logic [15:0] shift_q, mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int          vectors = 0;
    int          errors  = 0;
    logic [15:0] m [5];
    logic [15:0] sh_exp;

    always #5 clk = ~clk;

    dbg_cmd_exec uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .shift_en(shift_en), .busy(busy), .done(done),
        .shift_q(shift_q), .ser_out(ser_out), .go_pulse(go_pulse),
        .step_pulse(step_pulse), .tag_go_pulse(tag_go_pulse),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [15:0] rd_fn(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    function automatic logic is_known(input logic [7:0] op);
        return (op >= 8'h62 && op <= 8'h67) || (op >= 8'h42 && op <= 8'h47) ||
               op == 8'h08 || op == 8'h10 || op == 8'h18;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Check pulse outputs: expected one-hot {go, step, tag}.
    task automatic chk_pulses(input string req, input logic [2:0] exp);
        chk(req, {29'd0, go_pulse, step_pulse, tag_go_pulse}, {29'd0, exp});
    endtask

    // Offer one command and check everything due, including memory handshake.
    task automatic run_cmd(input logic [7:0] op, input logic [15:0] wd);
        logic [15:0] a;
        int lat;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op >= 8'h63 && op <= 8'h67) begin
            sh_exp = m[op - 8'h63];
            chk("R2 done", {31'd0, done}, 32'd1);
            chk("R2 shift", {16'd0, shift_q}, {16'd0, sh_exp});
            chk_pulses("R2 pulses", 3'b000);
        end else if (op >= 8'h43 && op <= 8'h47) begin
            m[op - 8'h43] = wd;
            chk("R3 done", {31'd0, done}, 32'd1);
            chk("R3 shift", {16'd0, shift_q}, {16'd0, sh_exp});
        end else if (op == 8'h62 || op == 8'h42) begin
            m[2] = m[2] + 16'd2;
            a = m[2];
            chk("R6 req", {31'd0, mem_req}, 32'd1);
            chk("R11 busy", {31'd0, busy}, 32'd1);
            chk(op == 8'h62 ? "R4 addr" : "R5 addr", {16'd0, mem_addr}, {16'd0, a});
            chk("R4 we", {31'd0, mem_we}, {31'd0, op == 8'h42});
            if (op == 8'h42) chk("R5 wdata", {16'd0, mem_wdata}, {16'd0, wd});
            lat = int'($urandom % 4);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk("R6 held", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, a});
                chk("R11 no done", {31'd0, done}, 32'd0);
            end
            mem_ack = 1'b1; mem_rdata = rd_fn(a);
            @(negedge clk);
            mem_ack = 1'b0; mem_rdata = 16'hDEAD;
            if (op == 8'h62) sh_exp = rd_fn(a);
            chk(op == 8'h62 ? "R4 done" : "R5 done", {31'd0, done}, 32'd1);
            chk("R6 drop", {30'd0, mem_req, busy}, 32'd0);
            chk(op == 8'h62 ? "R4 shift" : "R5 shift", {16'd0, shift_q}, {16'd0, sh_exp});
        end else if (op == 8'h08) begin
            chk("R7 done", {31'd0, done}, 32'd1);
            chk_pulses("R7 go", 3'b100);
        end else if (op == 8'h10) begin
            chk("R8 done", {31'd0, done}, 32'd1);
            chk_pulses("R8 step", 3'b010);
        end else if (op == 8'h18) begin
            chk("R9 done", {31'd0, done}, 32'd1);
            chk_pulses("R9 tag", 3'b001);
        end else begin
            chk("R10 no done", {31'd0, done}, 32'd0);
            chk_pulses("R10 pulses", 3'b000);
            chk("R10 shift", {16'd0, shift_q}, {16'd0, sh_exp});
            chk("R10 no req", {31'd0, mem_req}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0] unk [6] = '{8'h00, 8'h41, 8'h48, 8'h61, 8'h68, 8'hFF};
        logic [7:0] op;
        void'($urandom(32'd2024));
        for (int i = 0; i < 5; i++) m[i] = '0;
        sh_exp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 outputs", {25'd0, done, busy, mem_req, go_pulse, step_pulse, tag_go_pulse, ser_out},
            32'd0);
        chk("R1 shift", {16'd0, shift_q}, 32'd0);
        for (int r = 0; r < 5; r++) run_cmd(8'h63 + 8'(r), 16'h0);

        // Directed: write each register, then read back in order (R2, R3)
        for (int r = 0; r < 5; r++) run_cmd(8'h43 + 8'(r), 16'h1111 * 16'(r + 1));
        for (int r = 0; r < 5; r++) run_cmd(8'h63 + 8'(r), 16'h0);

        // R4 wrap of X near top of range
        run_cmd(8'h45, 16'hFFFF);
        run_cmd(8'h62, 16'h0);
        run_cmd(8'h65, 16'h0);
        run_cmd(8'h42, 16'hA5A5);

        // R11: command offered while busy is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 8'h62;
        @(negedge clk);
        cmd_op = 8'h43; cmd_wdata = 16'hBEEF;
        m[2] = m[2] + 16'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11 busy hold", {31'd0, busy}, 32'd1);
        mem_ack = 1'b1; mem_rdata = rd_fn(m[2]);
        @(negedge clk);
        mem_ack = 1'b0;
        sh_exp = rd_fn(m[2]);
        chk("R11 done", {31'd0, done}, 32'd1);
        run_cmd(8'h63, 16'h0);

        // R12: shifting with zero fill and MSB on ser_out
        @(negedge clk);
        shift_en = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk("R12 shift", {16'd0, shift_q}, {16'd0, sh_exp << k});
            chk("R12 ser", {31'd0, ser_out}, {31'd0, shift_q[15]});
        end
        sh_exp = sh_exp << 5;
        // R12: load wins over shift
        run_cmd(8'h66, 16'h0);
        shift_en = 1'b0;

        // R10 directed unknown codes
        for (int u = 0; u < 6; u++) run_cmd(unk[u], 16'h7777);
        for (int r = 0; r < 5; r++) run_cmd(8'h63 + 8'(r), 16'h0);

        // Random mix of all codes
        for (int n = 0; n < 400; n++) begin
            case ($urandom % 16)
                0:  op = 8'h62;
                1, 2, 3: op = 8'h63 + 8'($urandom % 5);
                4:  op = 8'h42;
                5, 6, 7: op = 8'h43 + 8'($urandom % 5);
                8:  op = 8'h08;
                9:  op = 8'h10;
                10: op = 8'h18;
                default: begin
                    op = 8'($urandom);
                    if (is_known(op)) op = unk[$urandom % 6];
                end
            endcase
            run_cmd(op, 16'($urandom));
        end
        for (int r = 0; r < 5; r++) run_cmd(8'h63 + 8'(r), 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule